// File: doc/BRIEF.md
# Three-Mode Interval Timer Array

A group of identical interval timers, three by default, that share one status word and one global enable. Each timer is set by its own configuration word to one of three jobs. It can drive a pulse waveform on its pin. It can measure the high time and the full period of a signal arriving on its pin. It can count edges on its pin as an external-event watchdog. Each timer has a 7-bit configuration word and three counter-width registers: count, period and pulse width.

Software reaches every register through a simple word-wide write strobe and a combinational read port. The block sends one interrupt line per timer to the chip's interrupt controller. Each pin is split into input, output and output-enable signals so that the pad ring can build the bidirectional pad. Pin inputs pass through a synchronizer before any edge is detected.

Top module: `tmr_array`

## Requirements
- R1: After reset every configuration word, count, period, pulse width, status bit and the global enable read as zero, and all `irq` and `pin_oe` bits are low.
- R2: Timer i owns addresses 4i (configuration, 7 bits), 4i+1 (count), 4i+2 (period) and 4i+3 (pulse width). Address 4N is the status word and 4N+1 is the global enable (bit 0). Written values read back unchanged.
- R3: Timer i runs only when global enable bit 0 and its configuration bit 0 (enable) are both 1. While it does not run, its count holds, except when software writes it.
- R4: Configuration bits [2:1] select the mode: 00 waveform, 01 capture, 10 watchdog, 11 hold. In waveform mode a running timer drives `pin_out` high while count < pulse width and low otherwise. The count advances by one each clock.
- R5: In waveform mode the count goes from period-1 back to 0, and that wrap sets the timer's interrupt flag.
- R6: In capture mode a synchronized rising edge loads count with 1. The following falling edge stores the count into pulse width. The next rising edge stores the count into period and loads 1 again. A high time of H clocks followed by a low time of L clocks therefore yields pulse width H and period H+L.
- R7: The rising edge that completes a capture sets the timer's interrupt flag.
- R8: If the count would wrap past all ones while a capture is under way, the timer's overflow flag is set and the capture returns to waiting for a rising edge. The overflow flag stays set until software clears it.
- R9: In watchdog mode the count advances on each synchronized pin edge of the polarity chosen by configuration bit 3 (0 rising, 1 falling). When it reaches period, it returns to 0 and sets the interrupt flag.
- R10: Status bits [N-1:0] are the interrupt flags, [2N-1:N] the overflow flags and [3N-1:2N] the running state. Writing 1 to a flag bit clears it, writing 0 leaves it alone, and a new event in the same cycle wins over the clear.
- R11: `irq[i]` is high exactly when timer i's interrupt flag is set and configuration bit 4 (interrupt enable) is 1.
- R12: `pin_oe[i]` is high only when timer i is enabled in its configuration word and in waveform mode. In capture and watchdog modes the pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr`, combinational |
| pin_in | input | NUM_TMR | Pad input of each timer pin |
| pin_out | output | NUM_TMR | Pad output value of each timer pin |
| pin_oe | output | NUM_TMR | Pad output enable of each timer pin |
| irq | output | NUM_TMR | Interrupt request per timer |

## Verification
Several properties are checked on every cycle:
- the write-one-to-clear and set-wins-over-clear rules of the flags;
- the holding of a stopped counter;
- the waveform wrap from period-1 to 0;
- the stickiness of overflow;
- the gating of interrupts by their enable bit;
- output-enable only in waveform mode.

Other behaviour can only be shown by the bench's scenarios, because it depends on how a pin signal evolves over time. This covers the captured pulse width and period for a table of high and low times, the number of high cycles per waveform period, and edge counting with either polarity. It also covers the overflow of a capture held high past the counter range.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int CFG_W     = 7;
   localparam int CFG_EN    = 0;
   localparam int CFG_MODE  = 1;
   localparam int CFG_POL   = 3;
   localparam int CFG_IRQEN = 4;

   typedef enum logic [1:0] {
      TM_WAVE = 2'b00,
      TM_CAPT = 2'b01,
      TM_WDOG = 2'b10,
      TM_HOLD = 2'b11
   } tmr_mode_e;

   typedef enum logic [1:0] {
      CP_IDLE = 2'b00,
      CP_HIGH = 2'b01,
      CP_LOW  = 2'b10
   } cap_st_e;
endpackage

// File: rtl/tmr_edge.sv
module tmr_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic rise,
   output logic fall
);
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= {sh_q[STAGES-1:0], pin};
   end

   assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
   assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_pkg::*;
#(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CFG_W-1:0] cfg,
   input  logic             rise,
   input  logic             fall,
   input  logic             wr_cnt,
   input  logic             wr_per,
   input  logic             wr_pw,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] per,
   output logic [CNT_W-1:0] pw,
   output logic             pin_out,
   output logic             pin_oe,
   output logic             evt,
   output logic             ovf_evt
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   tmr_mode_e        mode;
   cap_st_e          st_q, st_d;
   logic [CNT_W-1:0] cnt_d, per_d, pw_d;
   logic             hit;

   assign mode = tmr_mode_e'(cfg[CFG_MODE +: 2]);
   assign hit  = cfg[CFG_POL] ? fall : rise;

   always_comb begin
      cnt_d   = cnt;
      per_d   = per;
      pw_d    = pw;
      st_d    = st_q;
      evt     = 1'b0;
      ovf_evt = 1'b0;
      if (!run) begin
         st_d = CP_IDLE;
      end else begin
         case (mode)
            TM_WAVE: begin
               if (cnt == per - ONE) begin
                  cnt_d = '0;
                  evt   = 1'b1;
               end else begin
                  cnt_d = cnt + ONE;
               end
            end
            TM_CAPT: begin
               case (st_q)
                  CP_IDLE: begin
                     if (rise) begin
                        cnt_d = ONE;
                        st_d  = CP_HIGH;
                     end
                  end
                  CP_HIGH: begin
                     if (fall) begin
                        pw_d  = cnt;
                        cnt_d = cnt + ONE;
                        st_d  = CP_LOW;
                     end else if (&cnt) begin
                        cnt_d   = '0;
                        ovf_evt = 1'b1;
                        st_d    = CP_IDLE;
                     end else begin
                        cnt_d = cnt + ONE;
                     end
                  end
                  CP_LOW: begin
                     if (rise) begin
                        per_d = cnt;
                        cnt_d = ONE;
                        evt   = 1'b1;
                        st_d  = CP_HIGH;
                     end else if (&cnt) begin
                        cnt_d   = '0;
                        ovf_evt = 1'b1;
                        st_d    = CP_IDLE;
                     end else begin
                        cnt_d = cnt + ONE;
                     end
                  end
                  default: st_d = CP_IDLE;
               endcase
            end
            TM_WDOG: begin
               if (hit) begin
                  if (cnt + ONE == per) begin
                     cnt_d = '0;
                     evt   = 1'b1;
                  end else begin
                     cnt_d = cnt + ONE;
                  end
               end
            end
            default: ;
         endcase
      end
      if (wr_cnt) cnt_d = wdata;
      if (wr_per) per_d = wdata;
      if (wr_pw)  pw_d  = wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         per  <= '0;
         pw   <= '0;
         st_q <= CP_IDLE;
      end else begin
         cnt  <= cnt_d;
         per  <= per_d;
         pw   <= pw_d;
         st_q <= st_d;
      end
   end

   assign pin_oe  = cfg[CFG_EN] && (mode == TM_WAVE);
   assign pin_out = run && (mode == TM_WAVE) && (cnt < pw);
endmodule

// File: rtl/tmr_array.sv
module tmr_array
   import tmr_pkg::*;
#(
   parameter int NUM_TMR     = 3,
   parameter int CNT_W       = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [CNT_W-1:0]    reg_wdata,
   output logic [CNT_W-1:0]    reg_rdata,
   input  logic [NUM_TMR-1:0]  pin_in,
   output logic [NUM_TMR-1:0]  pin_out,
   output logic [NUM_TMR-1:0]  pin_oe,
   output logic [NUM_TMR-1:0]  irq
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4 * NUM_TMR);
   localparam logic [ADDR_W-1:0] GEN_A  = ADDR_W'(4 * NUM_TMR + 1);
   localparam int                IDX_W  = ADDR_W - 2;

   if (CNT_W < 3 * NUM_TMR || CNT_W < CFG_W) begin : g_bad_width
      $error("tmr_array: CNT_W too narrow for status or configuration");
   end
   if (4 * NUM_TMR + 2 > 2 ** ADDR_W) begin : g_bad_addr
      $error("tmr_array: ADDR_W too small for register map");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tmr_array: SYNC_STAGES must be at least 2");
   end

   logic [NUM_TMR-1:0][CFG_W-1:0] cfg_q;
   logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q, per_q, pw_q;
   logic [NUM_TMR-1:0]            rise, fall, run, ev, ovf_ev;
   logic [NUM_TMR-1:0]            st_int, st_ovf, clr_int, clr_ovf;
   logic                          gen_q, stat_wr;

   assign stat_wr = reg_we && (reg_addr == STAT_A);
   assign clr_int = stat_wr ? reg_wdata[NUM_TMR-1:0] : '0;
   assign clr_ovf = stat_wr ? reg_wdata[2*NUM_TMR-1:NUM_TMR] : '0;

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
      logic wr_cfg, wr_cnt, wr_per, wr_pw;
      assign wr_cfg = reg_we && (reg_addr == ADDR_W'(4 * i));
      assign wr_cnt = reg_we && (reg_addr == ADDR_W'(4 * i + 1));
      assign wr_per = reg_we && (reg_addr == ADDR_W'(4 * i + 2));
      assign wr_pw  = reg_we && (reg_addr == ADDR_W'(4 * i + 3));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      cfg_q[i] <= '0;
         else if (wr_cfg) cfg_q[i] <= reg_wdata[CFG_W-1:0];
      end

      assign run[i] = gen_q && cfg_q[i][CFG_EN];
      assign irq[i] = st_int[i] && cfg_q[i][CFG_IRQEN];

      tmr_edge #(.STAGES(SYNC_STAGES)) u_edge (
         .clk  (clk),
         .rst_n(rst_n),
         .pin  (pin_in[i]),
         .rise (rise[i]),
         .fall (fall[i])
      );

      tmr_chan #(.CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run[i]),
         .cfg    (cfg_q[i]),
         .rise   (rise[i]),
         .fall   (fall[i]),
         .wr_cnt (wr_cnt),
         .wr_per (wr_per),
         .wr_pw  (wr_pw),
         .wdata  (reg_wdata),
         .cnt    (cnt_q[i]),
         .per    (per_q[i]),
         .pw     (pw_q[i]),
         .pin_out(pin_out[i]),
         .pin_oe (pin_oe[i]),
         .evt    (ev[i]),
         .ovf_evt(ovf_ev[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_q  <= 1'b0;
         st_int <= '0;
         st_ovf <= '0;
      end else begin
         if (reg_we && reg_addr == GEN_A) gen_q <= reg_wdata[0];
         st_int <= (st_int & ~clr_int) | ev;
         st_ovf <= (st_ovf & ~clr_ovf) | ovf_ev;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == STAT_A) begin
         reg_rdata = CNT_W'({run, st_ovf, st_int});
      end else if (reg_addr == GEN_A) begin
         reg_rdata = CNT_W'(gen_q);
      end else begin
         for (int i = 0; i < NUM_TMR; i++) begin
            if (reg_addr[ADDR_W-1:2] == IDX_W'(i)) begin
               case (reg_addr[1:0])
                  2'd0:    reg_rdata = CNT_W'(cfg_q[i]);
                  2'd1:    reg_rdata = cnt_q[i];
                  2'd2:    reg_rdata = per_q[i];
                  default: reg_rdata = pw_q[i];
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/tmr_array_chk.sv
module tmr_array_chk
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 3,
   parameter int CNT_W   = 32,
   parameter int ADDR_W  = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          reg_we,
   input logic [ADDR_W-1:0]             reg_addr,
   input logic [CNT_W-1:0]              reg_wdata,
   input logic [NUM_TMR-1:0]            pin_oe,
   input logic [NUM_TMR-1:0]            irq,
   input logic [NUM_TMR-1:0][CFG_W-1:0] cfg_q,
   input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_q,
   input logic [NUM_TMR-1:0][CNT_W-1:0] per_q,
   input logic [NUM_TMR-1:0]            run,
   input logic [NUM_TMR-1:0]            ev,
   input logic [NUM_TMR-1:0]            ovf_ev,
   input logic [NUM_TMR-1:0]            st_int,
   input logic [NUM_TMR-1:0]            st_ovf
);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(4 * NUM_TMR);

   for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
      logic clr_i, clr_o, wr_c, wr_p, wave;
      assign clr_i = reg_we && reg_addr == STAT_A && reg_wdata[i];
      assign clr_o = reg_we && reg_addr == STAT_A && reg_wdata[NUM_TMR + i];
      assign wr_c  = reg_we && reg_addr == ADDR_W'(4 * i + 1);
      assign wr_p  = reg_we && reg_addr == ADDR_W'(4 * i + 2);
      assign wave  = cfg_q[i][CFG_MODE +: 2] == TM_WAVE;

      p_gate_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!run[i] && !wr_c) |=> $stable(cnt_q[i]));

      p_wave_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (run[i] && wave && !wr_c && !wr_p && per_q[i] != '0
          && cnt_q[i] == per_q[i] - CNT_W'(1)) |=> (cnt_q[i] == '0 && st_int[i]));

      p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (st_ovf[i] && !clr_o) |=> st_ovf[i]);

      p_w1c_r10: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !ev[i]) |=> !st_int[i]);

      p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> st_int[i]);

      p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
         irq[i] |-> (st_int[i] && cfg_q[i][CFG_IRQEN]));

      p_oe_mode_r12: assert property (@(posedge clk) disable iff (!rst_n)
         pin_oe[i] |-> (wave && cfg_q[i][CFG_EN]));
   end
endmodule

bind tmr_array tmr_array_chk #(
   .NUM_TMR(NUM_TMR),
   .CNT_W  (CNT_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .pin_oe   (pin_oe),
   .irq      (irq),
   .cfg_q    (cfg_q),
   .cnt_q    (cnt_q),
   .per_q    (per_q),
   .run      (run),
   .ev       (ev),
   .ovf_ev   (ovf_ev),
   .st_int   (st_int),
   .st_ovf   (st_ovf)
);

// File: tb/tmr_array_test.sv
module tmr_array_test;
   localparam int N  = 3;
   localparam int W  = 10;
   localparam int AW = 4;
   localparam logic [AW-1:0] A_STAT = 4'd12;
   localparam logic [AW-1:0] A_GEN  = 4'd13;

   // high cycles, low cycles, expected pulse width, expected period
   localparam int CAPV [5][4] = '{
      '{3, 4, 3, 7}, '{7, 2, 7, 9}, '{1, 1, 1, 2}, '{5, 10, 5, 15}, '{12, 6, 12, 18}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [W-1:0]  reg_wdata = '0;
   logic [W-1:0]  reg_rdata;
   logic [N-1:0]  pin_in = '0;
   logic [N-1:0]  pin_out, pin_oe, irq;
   int            total = 0;
   int            fails = 0;

   always #4 clk = ~clk;

   tmr_array #(.NUM_TMR(N), .CNT_W(W), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
      .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic chk(input string tag, input int got, input int exp);
      total++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input int d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = W'(d);
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output int d);
      reg_addr = a;
      #1 d = int'(reg_rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse2(input bit lvl_first);
      pin_in[2] = lvl_first; idle(3);
      pin_in[2] = ~lvl_first; idle(3);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int v, v2, highs;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      rd(4'd0, v);   chk("R1 cfg0", v, 0);
      rd(4'd9, v);   chk("R1 cnt2", v, 0);
      rd(A_STAT, v); chk("R1 status", v, 0);
      rd(A_GEN, v);  chk("R1 gen", v, 0);
      chk("R1 irq", int'(irq), 0);
      chk("R1 oe", int'(pin_oe), 0);

      // R2 readback
      wr(4'd10, 'h155); rd(4'd10, v); chk("R2 per2", v, 'h155);
      wr(4'd7, 'h2AA);  rd(4'd7, v);  chk("R2 pw1", v, 'h2AA);

      // R4/R5 waveform on timer 0: period 5, pulse width 2, irq enabled
      wr(4'd2, 5); wr(4'd3, 2); wr(4'd1, 0);
      wr(A_GEN, 1);
      wr(4'd0, 'h11);
      highs = 0;
      for (int k = 0; k < 20; k++) begin
         if (pin_out[0]) highs++;
         if (k != 19) @(negedge clk);
      end
      chk("R4 high cycles", highs, 8);
      chk("R12 oe in waveform", int'(pin_oe[0]), 1);
      rd(A_STAT, v); chk("R5 wrap flag", v & 1, 1);
      chk("R11 irq0 enabled", int'(irq[0]), 1);
      rd(4'd1, v); chk("R5 count below period", int'(v < 5), 1);

      // R3 per-timer enable off
      wr(4'd0, 'h10);
      rd(4'd1, v); idle(10); rd(4'd1, v2);
      chk("R3 cfg-off hold", v2, v);
      chk("R12 oe off when disabled", int'(pin_oe[0]), 0);

      // R10 write one to clear
      wr(A_STAT, 1); rd(A_STAT, v); chk("R10 clear int0", v & 1, 0);
      chk("R11 irq0 after clear", int'(irq[0]), 0);

      // R3 global enable off
      wr(A_GEN, 0); wr(4'd0, 'h11);
      rd(4'd1, v); idle(10); rd(4'd1, v2);
      chk("R3 global-off hold", v2, v);
      chk("R3 pin low when stopped", int'(pin_out[0]), 0);
      rd(A_STAT, v); chk("R10 run bit clear", (v >> 6) & 1, 0);
      wr(4'd0, 0); wr(A_GEN, 1);

      // R6/R7 capture table on timer 1
      foreach (CAPV[j]) begin
         pin_in[1] = 1'b0;
         wr(4'd4, 0);
         wr(A_STAT, 'h2);
         wr(4'd4, 'h13);
         idle(3);
         pin_in[1] = 1'b1; idle(CAPV[j][0]);
         pin_in[1] = 1'b0; idle(CAPV[j][1]);
         pin_in[1] = 1'b1; idle(6);
         rd(4'd7, v); chk($sformatf("R6 pw vec%0d", j), v, CAPV[j][2]);
         rd(4'd6, v); chk($sformatf("R6 per vec%0d", j), v, CAPV[j][3]);
         rd(A_STAT, v); chk($sformatf("R7 flag vec%0d", j), (v >> 1) & 1, 1);
         chk("R12 capture pin is input", int'(pin_oe[1]), 0);
      end
      wr(4'd4, 0); pin_in[1] = 1'b0; idle(3);

      // R8 overflow: hold high past counter range
      wr(A_STAT, 'h3F);
      wr(4'd4, 'h03);
      idle(3);
      pin_in[1] = 1'b1; idle(1100);
      rd(A_STAT, v);
      chk("R8 overflow set", (v >> 4) & 1, 1);
      chk("R8 no capture flag", (v >> 1) & 1, 0);
      wr(A_STAT, 'h10); rd(A_STAT, v);
      chk("R8 overflow cleared", (v >> 4) & 1, 0);
      wr(4'd4, 0); pin_in[1] = 1'b0; idle(3);

      // R9 watchdog rising edges on timer 2, period 3
      wr(4'd10, 3); wr(4'd9, 0);
      wr(4'd8, 'h15);
      pulse2(1'b1); pulse2(1'b1);
      rd(4'd9, v); chk("R9 two edges", v, 2);
      rd(A_STAT, v); chk("R9 no flag yet", (v >> 2) & 1, 0);
      pulse2(1'b1);
      rd(4'd9, v); chk("R9 wrap count", v, 0);
      rd(A_STAT, v); chk("R9 flag at period", (v >> 2) & 1, 1);
      chk("R11 irq2 enabled", int'(irq[2]), 1);
      chk("R12 watchdog pin is input", int'(pin_oe[2]), 0);

      // R9 falling polarity
      wr(A_STAT, 4); wr(4'd9, 0); wr(4'd8, 'h1D);
      pin_in[2] = 1'b1; idle(4);
      rd(4'd9, v); chk("R9 falling ignores rise", v, 0);
      pin_in[2] = 1'b0; idle(4);
      rd(4'd9, v); chk("R9 falling counts", v, 1);

      // R11 interrupt masked
      wr(4'd9, 0); wr(4'd8, 'h05);
      pulse2(1'b1); pulse2(1'b1); pulse2(1'b1);
      rd(A_STAT, v); chk("R11 flag set while masked", (v >> 2) & 1, 1);
      chk("R11 irq2 masked", int'(irq[2]), 0);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule